// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

This block turns a vector of active-low request lines into the binary index of the highest-numbered line that is asserted. It is purely combinational. The code comes out bit-inverted, so the top request line gives an all-zeros code. An active-low enable input can gate the whole encoder off. A group flag reports whether any request is present. An enable output goes low only when the encoder is enabled and idle, which lets a lower-priority encoder take over.

A build-time switch selects one of two variants. The single-stage variant is an eight-input encoder with a three-bit code. The chained variant joins two stages into a sixteen-input encoder with a four-bit code. In the chained variant the upper stage handles requests 15 to 8, and its enable output drives the lower stage's enable input. Code bit 3 comes from the upper stage's group flag. The lower three code bits are the bitwise AND of the two stages' codes.

Top module: `prienc_top`

## Requirements
- R1: While `enInN` is 1, every bit of `codeN` is 1, `groupN` is 1 and `enOutN` is 1, whatever `reqN` holds.
- R2: While `enInN` is 0, `groupN` is 0 exactly when at least one bit of `reqN` is 0.
- R3: The bit of `reqN` with the highest index that is 0 wins, and lower-index requests do not change the code.
- R4: When a request wins, `codeN` equals the bitwise complement of its index. In the eight-input variant, request 7 gives 3'b000 and request 0 gives 3'b111.
- R5: `enOutN` is 0 exactly when `enInN` is 0 and every bit of `reqN` is 1.
- R6: When enabled with no request, `codeN` is all ones and `groupN` is 1. When request 0 alone wins, `codeN` is all ones and `groupN` is 0, so `groupN` tells the two cases apart.
- R7: With `CASCADE`=1, `reqN` is 16 bits wide, `codeN` is 4 bits and equals the complement of the winning index 0..15. `groupN` is 0 when any of the 16 requests is 0, and `enOutN` is 0 only when the block is enabled and all 16 requests are idle.
- R8: With `CASCADE`=1, code bit 3 is 0 exactly when the winner lies among requests 15..8. A pending request in the upper half masks every request in the lower half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reqN | input | NUM_REQ (8, or 16 when chained) | Active-low request lines, index NUM_REQ-1 highest priority |
| enInN | input | 1 | Active-low encoder enable |
| codeN | output | CODE_W (3, or 4 when chained) | Complemented index of the winning request |
| groupN | output | 1 | Low when enabled and any request is present |
| enOutN | output | 1 | Low when enabled and no request is present; feeds a following stage |

## Verification
The block has no registers, so every output is due in the same cycle its inputs change, and no cycle offset applies. The bench drives each input pattern on the falling clock edge and samples all three outputs a few nanoseconds later, well before the next rising edge. An independent model in the bench computes the expected values, and the outputs are compared against it. The eight-input variant is swept over every request and enable combination. The chained variant is driven with patterns that pin the winner to each of the 16 positions, with pseudo-random filler below the winner.

// File: rtl/prienc_pkg.sv
package prienc_pkg;
  localparam int BASE_WAYS = 8;

  typedef struct packed {
    logic enabled;
    logic anyReq;
  } encStrobe_t;
endpackage

// File: rtl/prienc_ctrl.sv
module prienc_ctrl
  import prienc_pkg::*;
#(
  parameter int WAYS = BASE_WAYS
) (
  input  logic [WAYS-1:0] reqN,
  input  logic            enInN,
  output encStrobe_t      strobe,
  output logic            groupN,
  output logic            enOutN
);
  always_comb begin
    strobe.enabled = ~enInN;
    strobe.anyReq  = ~(&reqN);
    groupN         = ~(strobe.enabled & strobe.anyReq);
    enOutN         = ~(strobe.enabled & ~strobe.anyReq);
  end
endmodule

// File: rtl/prienc_dp.sv
module prienc_dp
  import prienc_pkg::*;
#(
  parameter int WAYS  = BASE_WAYS,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  reqN,
  input  encStrobe_t       strobe,
  output logic [IDX_W-1:0] codeN
);
  logic [IDX_W-1:0] winIdx;

  // Ascending scan: a later (higher) low input overwrites earlier ones.
  always_comb begin
    winIdx = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!reqN[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    if (strobe.enabled && strobe.anyReq) codeN = ~winIdx;
    else                                 codeN = '1;
  end
endmodule

// File: rtl/prienc_stage.sv
module prienc_stage
  import prienc_pkg::*;
#(
  parameter int WAYS  = BASE_WAYS,
  localparam int IDX_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  reqN,
  input  logic             enInN,
  output logic [IDX_W-1:0] codeN,
  output logic             groupN,
  output logic             enOutN
);
  encStrobe_t strobe;

  prienc_ctrl #(.WAYS(WAYS)) ctrl_i (
    .reqN   (reqN),
    .enInN  (enInN),
    .strobe (strobe),
    .groupN (groupN),
    .enOutN (enOutN)
  );

  prienc_dp #(.WAYS(WAYS)) dp_i (
    .reqN   (reqN),
    .strobe (strobe),
    .codeN  (codeN)
  );
endmodule

// File: rtl/prienc_top.sv
module prienc_top
  import prienc_pkg::*;
#(
  parameter bit  CASCADE    = 1'b0,
  parameter int  STAGE_WAYS = BASE_WAYS,
  localparam int SIDX_W     = $clog2(STAGE_WAYS),
  localparam int NUM_REQ    = CASCADE ? 2 * STAGE_WAYS : STAGE_WAYS,
  localparam int CODE_W     = CASCADE ? SIDX_W + 1 : SIDX_W
) (
  input  logic [NUM_REQ-1:0] reqN,
  input  logic               enInN,
  output logic [CODE_W-1:0]  codeN,
  output logic               groupN,
  output logic               enOutN
);
  generate
    if (CASCADE) begin : g_chain
      logic [SIDX_W-1:0] upCode, loCode;
      logic              upGroupN, loGroupN, upEnOutN;

      prienc_stage #(.WAYS(STAGE_WAYS)) upper_i (
        .reqN   (reqN[NUM_REQ-1:STAGE_WAYS]),
        .enInN  (enInN),
        .codeN  (upCode),
        .groupN (upGroupN),
        .enOutN (upEnOutN)
      );

      prienc_stage #(.WAYS(STAGE_WAYS)) lower_i (
        .reqN   (reqN[STAGE_WAYS-1:0]),
        .enInN  (upEnOutN),
        .codeN  (loCode),
        .groupN (loGroupN),
        .enOutN (enOutN)
      );

      assign codeN  = {upGroupN, upCode & loCode};
      assign groupN = upGroupN & loGroupN;
    end else begin : g_single
      prienc_stage #(.WAYS(STAGE_WAYS)) only_i (
        .reqN   (reqN),
        .enInN  (enInN),
        .codeN  (codeN),
        .groupN (groupN),
        .enOutN (enOutN)
      );
    end
  endgenerate
endmodule

// File: rtl/prienc_checker.sv
module prienc_checker #(
  parameter int NUM_REQ = 8,
  parameter int CODE_W  = 3
) (
  input logic [NUM_REQ-1:0] reqN,
  input logic               enInN,
  input logic [CODE_W-1:0]  codeN,
  input logic               groupN,
  input logic               enOutN
);
  logic [CODE_W-1:0]  pickIdx;
  logic [NUM_REQ-1:0] aboveLow;

  always_comb begin
    pickIdx  = ~codeN;
    aboveLow = ((~reqN) >> pickIdx) >> 1;
  end

  always_comb begin
    if (enInN) begin
      a_r1_disabled_ones: assert (codeN == '1 && groupN && enOutN)
        else $error("R1 disabled outputs not all high");
    end
    a_r2_group_any: assert (groupN == (enInN || (&reqN)))
      else $error("R2 group flag mismatch");
    a_r5_enout_idle: assert (enOutN == !((!enInN) && (&reqN)))
      else $error("R5 enable output mismatch");
    if (!groupN) begin
      a_r4_code_names_low: assert (!reqN[pickIdx])
        else $error("R4 code does not name a low request");
      a_r3_none_above: assert (aboveLow == '0)
        else $error("R3 higher request ignored");
    end else begin
      a_r6_idle_ones: assert (codeN == '1)
        else $error("R6 idle code not all ones");
    end
  end
endmodule

bind prienc_top prienc_checker #(.NUM_REQ(NUM_REQ), .CODE_W(CODE_W)) chk_i (
  .reqN   (reqN),
  .enInN  (enInN),
  .codeN  (codeN),
  .groupN (groupN),
  .enOutN (enOutN)
);

// File: tb/prienc_top_tb_top.sv
module prienc_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0]  reqN8;
  logic        en8N;
  logic [2:0]  code8;
  logic        grp8, eo8;

  logic [15:0] reqN16;
  logic        en16N;
  logic [3:0]  code16;
  logic        grp16, eo16;

  prienc_top dut_i (
    .reqN (reqN8), .enInN (en8N), .codeN (code8), .groupN (grp8), .enOutN (eo8)
  );

  prienc_top #(.CASCADE(1'b1)) dutWide_i (
    .reqN (reqN16), .enInN (en16N), .codeN (code16), .groupN (grp16), .enOutN (eo16)
  );

  // Independent model: n request lines, complemented index of highest low line.
  function automatic logic [5:0] model(input logic [15:0] r, input int n, input logic enN);
    int win = -1;
    logic [3:0] c;
    for (int i = 0; i < n; i++) if (!r[i]) win = i;
    if (enN) return 6'b111111;
    if (win < 0) return {4'hF, 1'b1, 1'b0};
    c = ~4'(win);
    return {c, 1'b0, 1'b1};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got code/grp/eo=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic apply8(input logic [7:0] r, input logic enN, input string tag);
    logic [5:0] e;
    @(negedge clk);
    reqN8 = r; en8N = enN;
    #3;
    e = model({8'hFF, r}, 8, enN);
    check(tag, {1'b1, code8, grp8, eo8}, {1'b1, e[4:0]});
  endtask

  task automatic apply16(input logic [15:0] r, input logic enN, input string tag);
    @(negedge clk);
    reqN16 = r; en16N = enN;
    #3;
    check(tag, {code16, grp16, eo16}, model(r, 16, enN));
  endtask

  task automatic test_reset_state;
    #3;
    check("R1 reset disabled", {1'b1, code8, grp8, eo8}, 6'b111111);
  endtask

  task automatic test_sweep8;
    for (int en = 0; en < 2; en++)
      for (int v = 0; v < 256; v++)
        apply8(8'(v), en[0], en[0] ? "R1 disabled sweep" : "R2 R3 R4 R5 enabled sweep");
  endtask

  task automatic test_edge8;
    apply8(8'hFF, 1'b0, "R6 idle all ones group high");
    apply8(8'hFE, 1'b0, "R6 input0 all ones group low");
    apply8(8'h7F, 1'b0, "R4 input7 gives 000");
    apply8(8'h00, 1'b0, "R3 all low picks 7");
    apply8(8'h00, 1'b1, "R1 disabled all low");
  endtask

  task automatic test_wide;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] r;
    for (int en = 0; en < 2; en++)
      for (int w = -1; w < 16; w++)
        for (int k = 0; k < 32; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          r = lfsr;
          for (int b = 0; b < 16; b++) if (b > w) r[b] = 1'b1;
          if (w >= 0) r[w] = 1'b0;
          apply16(r, en[0], (w >= 8) ? "R8 upper half masks lower" : "R7 chained encode");
        end
    apply16(16'hFFFF, 1'b0, "R7 chained idle enOut low");
    apply16(16'h7FFF, 1'b0, "R8 top request code 0000");
    apply16(16'hFEFF, 1'b0, "R8 request 8 with lower idle");
    apply16(16'hFFFE, 1'b0, "R7 request 0 only");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    reqN8 = 8'hFF; en8N = 1'b1;
    reqN16 = 16'hFFFF; en16N = 1'b1;
    test_reset_state();
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    test_sweep8();
    test_edge8();
    test_wide();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule